// File: doc/BRIEF.md
# Serially Configured Memory Device Control Registers

This block holds the control and configuration registers of a memory device that is set up over a daisy-chained serial bus. It receives request packets that have already been decoded. Each packet carries a 6-bit target-device field, a 12-bit register address, a write flag and 16 bits of data. A request is acted on only when its target field matches the device ID stored in the block. The block holds one read/write setup register and one read-only identity register. From the setup register it drives these outputs:

- the serial chain output;
- the nap and power-down self-refresh enables;
- the low-power refresh enable;
- the temperature-sense enable.

The block also decides whether a request to leave nap or power-down applies to this device. When the exit-select bit is 1, any exit request applies. When it is 0, the 6 data pins carry an exit address. That address is either a broadcast or a directed match against the low 5 bits of the ID. A disable bit blocks all exits.

Top module: `memdev_ctrl_regs`

## Requirements
- R1: After `rst_ni` is deasserted, a read of the setup register (address 0x021) returns 0x007F. Its fields are: device ID in bits 5:0 = 0x3F, repeater bit 6 = 1, exit-select bit 7 = 0, nap self-refresh bit 8 = 0, power-down self-refresh bit 9 = 0, low-power refresh bit 10 = 0, temperature-enable bit 11 = 0, temperature-status bit 12, disable bit 13 = 0, and bits 15:14 = 0.
- R2: A request whose `req_sdev_i` differs from the stored device ID does nothing. A read gives no `rd_valid_o`, and a write changes no state.
- R3: A matching write to 0x021 loads all writable fields. A matching read of any address raises `rd_valid_o` with the data exactly one cycle later. `rd_data_o` is 0 whenever `rd_valid_o` is 0.
- R4: A matching read of 0x023 returns the identity word. Its fields are: protocol version 1 in bits 5:0, manufacturer version in bits 11:6 (default 5), doubled-bank flag in bit 12 (default 1), and refresh-bank bits 3'b100 in bits 15:13. With the defaults the word is 0x9141.
- R5: Writes to 0x023 and to any address other than 0x021 or 0x023 are ignored. A read of an unknown address returns 0 with `rd_valid_o` set.
- R6: A pulse on `sio_rst_i` restores the reset values of R1 on the next edge, and takes priority over a write in the same cycle.
- R7: With the repeater bit at 1, `sio_o` equals `sio_i`. With it at 0, `sio_o` is 1.
- R8: A write cannot set the nap self-refresh enable while `in_nap_i` is 1, nor the power-down self-refresh enable while `in_pdn_i` is 1. Clearing either enable is always allowed.
- R9: Bit 12 of a setup-register read equals `temp_trip_i` when the temperature enable is 1, and 0 otherwise.
- R10: While the disable bit is 1, `exit_ack_o` never rises.
- R11: With exit-select at 1, an exit request is accepted whatever `exit_dq_i` holds.
- R12: With exit-select at 0, an exit request is accepted when `exit_dq_i[5]` is 1 (broadcast), or when `exit_dq_i[4:0]` equals device ID bits 4:0 (directed).
- R13: `exit_ack_o` is a registered pulse, high in the cycle after an accepted `exit_req_i`. It needs `in_nap_i` or `in_pdn_i` to be 1 in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sio_rst_i | input | 1 | Serial-chain reset, synchronous |
| req_valid_i | input | 1 | Decoded request present |
| req_sdev_i | input | 6 | Target device ID of the request |
| req_addr_i | input | 12 | Register address |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 16 | Read response data |
| sio_i | input | 1 | Serial chain input |
| sio_o | output | 1 | Serial chain output |
| in_nap_i | input | 1 | Device is in nap |
| in_pdn_i | input | 1 | Device is in power-down |
| temp_trip_i | input | 1 | Temperature trip input |
| exit_req_i | input | 1 | Low-power exit request strobe |
| exit_dq_i | input | 6 | Exit address on data pins |
| exit_ack_o | output | 1 | Exit accepted pulse |
| nap_sr_en_o | output | 1 | Nap self-refresh enable |
| pdn_sr_en_o | output | 1 | Power-down self-refresh enable |
| lp_sr_en_o | output | 1 | Low-power refresh interval enable |
| temp_en_o | output | 1 | Temperature sensing enable |

## Verification
The assertions assume that the nap and power-down mode inputs change only between clock edges. They also assume that the exit strobe and the decoded request fields are valid and stable across the edge that samples them. The bench changes every input at the falling edge or a quarter period after the rising edge, so each rising edge sees settled values. The bench never raises `sio_rst_i` together with a request. This keeps the priority case of R6 out of the reference model's sequencing, while the property for R6 still covers the repeater outcome.

// File: rtl/memdev_cfg_pkg.sv
package memdev_cfg_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned AW  = 12;
  localparam int unsigned IDW = 6;

  localparam logic [AW-1:0] ADDR_SETUP = 12'h021;
  localparam logic [AW-1:0] ADDR_IDENT = 12'h023;

  localparam int unsigned B_REP  = 6;
  localparam int unsigned B_XSEL = 7;
  localparam int unsigned B_NSR  = 8;
  localparam int unsigned B_PSR  = 9;
  localparam int unsigned B_LSR  = 10;
  localparam int unsigned B_TEN  = 11;
  localparam int unsigned B_TSQ  = 12;
  localparam int unsigned B_DIS  = 13;

  localparam logic [5:0] PROTO_VER = 6'd1;
  localparam logic [2:0] REF_BITS  = 3'b100;

  typedef struct packed {
    logic           dis;
    logic           temp_en;
    logic           lp_sr;
    logic           pdn_sr;
    logic           nap_sr;
    logic           exit_sel;
    logic           repeat_en;
    logic [IDW-1:0] dev_id;
  } setup_t;

  localparam setup_t SETUP_RST = '{dis: 1'b0, temp_en: 1'b0, lp_sr: 1'b0,
                                   pdn_sr: 1'b0, nap_sr: 1'b0, exit_sel: 1'b0,
                                   repeat_en: 1'b1, dev_id: '1};
endpackage

// File: rtl/memdev_setup_reg.sv
module memdev_setup_reg
  import memdev_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sio_rst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          in_nap_i,
  input  logic          in_pdn_i,
  output setup_t        setup_o
);
  setup_t q, d;
  logic   unused_wbits;

  assign unused_wbits = ^{wdata_i[DW-1:B_DIS+1], wdata_i[B_TSQ]};

  always_comb begin
    d = q;
    if (sio_rst_i) begin
      d = SETUP_RST;
    end else if (wr_en_i) begin
      d.dev_id    = wdata_i[IDW-1:0];
      d.repeat_en = wdata_i[B_REP];
      d.exit_sel  = wdata_i[B_XSEL];
      d.lp_sr     = wdata_i[B_LSR];
      d.temp_en   = wdata_i[B_TEN];
      d.dis       = wdata_i[B_DIS];
      // set blocked while in the matching mode, clear always allowed
      d.nap_sr    = wdata_i[B_NSR] & (q.nap_sr | ~in_nap_i);
      d.pdn_sr    = wdata_i[B_PSR] & (q.pdn_sr | ~in_pdn_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SETUP_RST;
    else         q <= d;
  end

  assign setup_o = q;
endmodule

// File: rtl/memdev_rd_port.sv
module memdev_rd_port
  import memdev_cfg_pkg::*;
#(
  parameter logic [5:0] MFR_VER  = 6'd5,
  parameter bit         DBL_BANK = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  setup_t        setup_i,
  input  logic          temp_trip_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [DW-1:0] IDENT_WORD = {REF_BITS, DBL_BANK, MFR_VER, PROTO_VER};

  logic [DW-1:0] setup_word, mux_data;

  always_comb begin
    setup_word               = '0;
    setup_word[IDW-1:0]      = setup_i.dev_id;
    setup_word[B_REP]        = setup_i.repeat_en;
    setup_word[B_XSEL]       = setup_i.exit_sel;
    setup_word[B_NSR]        = setup_i.nap_sr;
    setup_word[B_PSR]        = setup_i.pdn_sr;
    setup_word[B_LSR]        = setup_i.lp_sr;
    setup_word[B_TEN]        = setup_i.temp_en;
    setup_word[B_TSQ]        = setup_i.temp_en & temp_trip_i;
    setup_word[B_DIS]        = setup_i.dis;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_SETUP: mux_data = setup_word;
      ADDR_IDENT: mux_data = IDENT_WORD;
      default:    mux_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_en_i ? mux_data : '0;
    end
  end
endmodule

// File: rtl/memdev_exit_gate.sv
module memdev_exit_gate
  import memdev_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           exit_req_i,
  input  logic           in_nap_i,
  input  logic           in_pdn_i,
  input  logic [IDW-1:0] dq_i,
  input  logic           dis_i,
  input  logic           exit_sel_i,
  input  logic [IDW-2:0] dev_id_lo_i,
  output logic           ack_o
);
  logic addr_ok, accept;

  // pin IDW-1 flags broadcast, lower pins carry a directed address
  assign addr_ok = exit_sel_i | dq_i[IDW-1] | (dq_i[IDW-2:0] == dev_id_lo_i);
  assign accept  = exit_req_i & (in_nap_i | in_pdn_i) & ~dis_i & addr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= accept;
  end
endmodule

// File: rtl/memdev_ctrl_regs.sv
module memdev_ctrl_regs
  import memdev_cfg_pkg::*;
#(
  parameter logic [5:0] MFR_VER  = 6'd5,
  parameter bit         DBL_BANK = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sio_rst_i,
  input  logic           req_valid_i,
  input  logic [IDW-1:0] req_sdev_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic           req_wr_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o,
  input  logic           sio_i,
  output logic           sio_o,
  input  logic           in_nap_i,
  input  logic           in_pdn_i,
  input  logic           temp_trip_i,
  input  logic           exit_req_i,
  input  logic [IDW-1:0] exit_dq_i,
  output logic           exit_ack_o,
  output logic           nap_sr_en_o,
  output logic           pdn_sr_en_o,
  output logic           lp_sr_en_o,
  output logic           temp_en_o
);
  setup_t setup_q;
  logic   id_hit, wr_setup, rd_en;

  assign id_hit   = req_valid_i & (req_sdev_i == setup_q.dev_id);
  assign wr_setup = id_hit & req_wr_i & (req_addr_i == ADDR_SETUP);
  assign rd_en    = id_hit & ~req_wr_i;

  memdev_setup_reg u_setup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sio_rst_i (sio_rst_i),
    .wr_en_i   (wr_setup),
    .wdata_i   (req_wdata_i),
    .in_nap_i  (in_nap_i),
    .in_pdn_i  (in_pdn_i),
    .setup_o   (setup_q)
  );

  memdev_rd_port #(.MFR_VER(MFR_VER), .DBL_BANK(DBL_BANK)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en),
    .addr_i      (req_addr_i),
    .setup_i     (setup_q),
    .temp_trip_i (temp_trip_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  memdev_exit_gate u_exit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exit_req_i  (exit_req_i),
    .in_nap_i    (in_nap_i),
    .in_pdn_i    (in_pdn_i),
    .dq_i        (exit_dq_i),
    .dis_i       (setup_q.dis),
    .exit_sel_i  (setup_q.exit_sel),
    .dev_id_lo_i (setup_q.dev_id[IDW-2:0]),
    .ack_o       (exit_ack_o)
  );

  assign sio_o       = setup_q.repeat_en ? sio_i : 1'b1;
  assign nap_sr_en_o = setup_q.nap_sr;
  assign pdn_sr_en_o = setup_q.pdn_sr;
  assign lp_sr_en_o  = setup_q.lp_sr;
  assign temp_en_o   = setup_q.temp_en;
endmodule

// File: rtl/memdev_ctrl_sva.sv
module memdev_ctrl_sva
  import memdev_cfg_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sio_rst_i,
  input logic           sio_i,
  input logic           sio_o,
  input logic           in_nap_i,
  input logic           in_pdn_i,
  input logic           nap_sr_en_o,
  input logic           pdn_sr_en_o,
  input logic           exit_req_i,
  input logic           exit_ack_o,
  input logic           dis_i,
  input logic           rd_valid_o,
  input logic           req_valid_i,
  input logic           req_wr_i,
  input logic [IDW-1:0] req_sdev_i,
  input logic [IDW-1:0] dev_id_i
);
  a_r6_sio_rst_repeats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_rst_i |=> (sio_o == sio_i));

  a_r8_nap_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_nap_i && !nap_sr_en_o) |=> !nap_sr_en_o);

  a_r8_pdn_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pdn_i && !pdn_sr_en_o) |=> !pdn_sr_en_o);

  a_r10_dis_blocks_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_ack_o |-> !$past(dis_i));

  a_r13_ack_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_ack_o |-> $past(exit_req_i && (in_nap_i || in_pdn_i)));

  a_r2_rsp_needs_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(req_valid_i && !req_wr_i && (req_sdev_i == dev_id_i)));
endmodule

bind memdev_ctrl_regs memdev_ctrl_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sio_rst_i   (sio_rst_i),
  .sio_i       (sio_i),
  .sio_o       (sio_o),
  .in_nap_i    (in_nap_i),
  .in_pdn_i    (in_pdn_i),
  .nap_sr_en_o (nap_sr_en_o),
  .pdn_sr_en_o (pdn_sr_en_o),
  .exit_req_i  (exit_req_i),
  .exit_ack_o  (exit_ack_o),
  .dis_i       (setup_q.dis),
  .rd_valid_o  (rd_valid_o),
  .req_valid_i (req_valid_i),
  .req_wr_i    (req_wr_i),
  .req_sdev_i  (req_sdev_i),
  .dev_id_i    (setup_q.dev_id)
);

// File: tb/tb_memdev_ctrl_regs.sv
module tb_memdev_ctrl_regs;
  localparam int CLK_P = 10;
  localparam int Q     = CLK_P / 4;

  logic        clk = 0, rst_n = 0, sio_rst = 0;
  logic        rv = 0, wr = 0;
  logic [5:0]  sdev = 0;
  logic [11:0] addr = 0;
  logic [15:0] wdata = 0;
  logic        rd_valid, sio_o, exit_ack, nsr_o, psr_o, lsr_o, ten_o;
  logic [15:0] rd_data;
  logic        sio_i = 0, in_nap = 0, in_pdn = 0, trip = 0, xreq = 0;
  logic [5:0]  dq = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  memdev_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .sio_rst_i(sio_rst),
    .req_valid_i(rv), .req_sdev_i(sdev), .req_addr_i(addr), .req_wr_i(wr),
    .req_wdata_i(wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .sio_i(sio_i), .sio_o(sio_o), .in_nap_i(in_nap), .in_pdn_i(in_pdn),
    .temp_trip_i(trip), .exit_req_i(xreq), .exit_dq_i(dq), .exit_ack_o(exit_ack),
    .nap_sr_en_o(nsr_o), .pdn_sr_en_o(psr_o), .lp_sr_en_o(lsr_o), .temp_en_o(ten_o)
  );

  // behavioural reference model
  logic [5:0]  m_id;
  logic        m_rep, m_xsel, m_nsr, m_psr, m_lsr, m_ten, m_dis;
  logic        m_rv, m_ack;
  logic [15:0] m_rd;

  function automatic logic [15:0] m_read(input logic [11:0] a);
    if (a == 12'h021)
      return {2'b00, m_dis, m_ten & trip, m_ten, m_lsr, m_psr, m_nsr, m_xsel, m_rep, m_id};
    if (a == 12'h023)
      return 16'h9141;
    return 16'h0000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_id <= 6'h3F; m_rep <= 1; m_xsel <= 0; m_nsr <= 0; m_psr <= 0;
      m_lsr <= 0; m_ten <= 0; m_dis <= 0; m_rv <= 0; m_rd <= 0; m_ack <= 0;
    end else begin
      m_rv  <= rv && sdev == m_id && !wr;
      m_rd  <= (rv && sdev == m_id && !wr) ? m_read(addr) : 16'h0;
      m_ack <= xreq && (in_nap || in_pdn) && !m_dis && (m_xsel || dq[5] || dq[4:0] == m_id[4:0]);
      if (sio_rst) begin
        m_id <= 6'h3F; m_rep <= 1; m_xsel <= 0; m_nsr <= 0; m_psr <= 0;
        m_lsr <= 0; m_ten <= 0; m_dis <= 0;
      end else if (rv && wr && sdev == m_id && addr == 12'h021) begin
        m_id <= wdata[5:0]; m_rep <= wdata[6]; m_xsel <= wdata[7];
        m_lsr <= wdata[10]; m_ten <= wdata[11]; m_dis <= wdata[13];
        m_nsr <= (in_nap && !m_nsr) ? 1'b0 : wdata[8];
        m_psr <= (in_pdn && !m_psr) ? 1'b0 : wdata[9];
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(Q);
    if (rst_n && !done) begin
      chk("R7 sio_o", {15'd0, sio_o}, {15'd0, m_rep ? sio_i : 1'b1});
      chk("R8 nap_sr_en", {15'd0, nsr_o}, {15'd0, m_nsr});
      chk("R8 pdn_sr_en", {15'd0, psr_o}, {15'd0, m_psr});
      chk("R3 lp_sr_en", {15'd0, lsr_o}, {15'd0, m_lsr});
      chk("R9 temp_en", {15'd0, ten_o}, {15'd0, m_ten});
      chk("R12 exit_ack", {15'd0, exit_ack}, {15'd0, m_ack});
      chk("R2 rd_valid", {15'd0, rd_valid}, {15'd0, m_rv});
      chk("R3 rd_data", rd_data, m_rd);
    end
  end

  task automatic idle();
    @(negedge clk);
    rv = 0; wr = 0; xreq = 0; sio_rst = 0;
    @(posedge clk); #(Q);
  endtask

  task automatic t_write(input logic [5:0] s, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    rv = 1; wr = 1; sdev = s; addr = a; wdata = d; xreq = 0;
    @(posedge clk); #(Q);
  endtask

  task automatic t_read(input logic [5:0] s, input logic [11:0] a);
    @(negedge clk);
    rv = 1; wr = 0; sdev = s; addr = a; xreq = 0;
    @(posedge clk); #(Q);
  endtask

  task automatic t_exit(input logic [5:0] p);
    @(negedge clk);
    rv = 0; xreq = 1; dq = p;
    @(posedge clk); #(Q);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) sio_i <= ~sio_i;

  initial begin
    #(CLK_P * 2 + 1);
    rst_n = 1;
    idle();
    // R1 reset state
    t_read(6'h3F, 12'h021);
    chk("R1 reset word", rd_data, 16'h007F);
    chk("R1 reset valid", {15'd0, rd_valid}, 16'h1);
    // R2 id mismatch
    t_read(6'h00, 12'h021);
    chk("R2 mismatch read", {15'd0, rd_valid}, 16'h0);
    t_write(6'h01, 12'h021, 16'h0000);
    t_read(6'h3F, 12'h021);
    chk("R2 mismatch write", rd_data, 16'h007F);
    // R3 write then read with new id
    t_write(6'h3F, 12'h021, 16'h0C4A);
    t_read(6'h0A, 12'h021);
    chk("R3 readback", rd_data, 16'h0C4A);
    // R9 temperature status
    trip = 1;
    t_read(6'h0A, 12'h021);
    chk("R9 status on", rd_data, 16'h1C4A);
    t_write(6'h0A, 12'h021, 16'h044A);
    t_read(6'h0A, 12'h021);
    chk("R9 status gated", rd_data, 16'h044A);
    trip = 0;
    // R4 identity, R5 ignored writes and unknown reads
    t_write(6'h0A, 12'h023, 16'h0000);
    t_read(6'h0A, 12'h023);
    chk("R4 ident word", rd_data, 16'h9141);
    t_read(6'h0A, 12'h050);
    chk("R5 unknown valid", {15'd0, rd_valid}, 16'h1);
    chk("R5 unknown data", rd_data, 16'h0000);
    t_write(6'h0A, 12'h050, 16'hFFFF);
    t_read(6'h0A, 12'h021);
    chk("R5 unknown write", rd_data, 16'h044A);
    // R7 repeater off then on
    t_write(6'h0A, 12'h021, 16'h000A);
    idle(); idle();
    chk("R7 held high", {15'd0, sio_o}, 16'h1);
    t_write(6'h0A, 12'h021, 16'h004A);
    idle();
    // R8 self-refresh set blocking
    in_nap = 1;
    t_write(6'h0A, 12'h021, 16'h014A);
    idle();
    chk("R8 nap set blocked", {15'd0, nsr_o}, 16'h0);
    in_nap = 0;
    t_write(6'h0A, 12'h021, 16'h014A);
    idle();
    chk("R8 nap set ok", {15'd0, nsr_o}, 16'h1);
    in_nap = 1;
    t_write(6'h0A, 12'h021, 16'h004A);
    idle();
    chk("R8 nap clear ok", {15'd0, nsr_o}, 16'h0);
    in_nap = 0; in_pdn = 1;
    t_write(6'h0A, 12'h021, 16'h024A);
    idle();
    chk("R8 pdn set blocked", {15'd0, psr_o}, 16'h0);
    // R12 addressed exit
    t_exit(6'h20);
    chk("R12 broadcast", {15'd0, exit_ack}, 16'h1);
    t_exit(6'h0A);
    chk("R12 directed hit", {15'd0, exit_ack}, 16'h1);
    t_exit(6'h0B);
    chk("R12 directed miss", {15'd0, exit_ack}, 16'h0);
    t_exit(6'h2B);
    chk("R12 broadcast any", {15'd0, exit_ack}, 16'h1);
    // R13 mode needed, single pulse
    in_pdn = 0;
    t_exit(6'h20);
    chk("R13 no mode", {15'd0, exit_ack}, 16'h0);
    in_nap = 1;
    t_exit(6'h20);
    idle();
    chk("R13 pulse ends", {15'd0, exit_ack}, 16'h0);
    // R11 exit without address
    t_write(6'h0A, 12'h021, 16'h00CA);
    t_exit(6'h0B);
    chk("R11 no-address exit", {15'd0, exit_ack}, 16'h1);
    // R10 disable
    t_write(6'h0A, 12'h021, 16'h20CA);
    t_exit(6'h20);
    chk("R10 disabled", {15'd0, exit_ack}, 16'h0);
    idle();
    // R6 serial-chain reset
    @(negedge clk); sio_rst = 1;
    @(posedge clk); #(Q);
    idle();
    t_read(6'h3F, 12'h021);
    chk("R6 restored", rd_data, 16'h007F);
    chk("R6 repeats", {15'd0, sio_o}, {15'd0, sio_i});
    idle(); idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule